// File: doc/BRIEF.md
# Card Response Capture Shift Chain

This block receives the reply a memory card sends after a command and stores it where a host can read it. Command response bits arrive one at a time on a serial line. Each bit is marked by a single-cycle transfer-clock enable. The bits feed a chain of seventeen byte registers that acts as one long shift register. A bit enters at bit 0 of register 16 and moves toward register 0, then leaves from bit 7 of register 0. Old contents are never wiped by a new response. They keep moving down the chain and are lost only when they leave the far end.

A separate data response register takes eight more bits, but only when the command was an SPI command that carries write data. It keeps the last five of those bits. A pulse `arm` latches the byte count, the mode flag and the write flag for the next response. One pulse is raised when the command response has been taken, and a second pulse when the data response has been taken. The host reads any register by address. Writing any value to an address clears that register two transfer clock cycles later.

Top module: `resp_capture`

## Requirements
- R1: After reset all eighteen registers read 0x00, and `cmd_done` and `dat_done` are low.
- R2: During command capture, each enable edge moves `rsp_bit` into bit 0 of register 16. Every byte shifts one position toward register 0, bit 7 of each register feeds bit 0 of the register below it, and bit 7 of register 0 is dropped.
- R3: A command response shifts exactly min(`rsp_bytes`,17)×8 times. A count of 0 shifts nothing, and counts above 17 act as 17.
- R4: Contents are not cleared between commands. Bytes from earlier responses continue down the chain on later responses.
- R5: A host write to address k (0 to 17) leaves register k unchanged through the first enable edge after the write. At the second enable edge register k becomes 0x00. Edges count whether or not capture is active.
- R6: If a clear lands on an edge where register k also shifts, register k becomes 0x00 except bit 0, which takes the incoming bit.
- R7: The data response register shifts on the 8 enable edges that follow the command end edge, but only if `spi_mode` and `wr_data` were both 1 at `arm`. Otherwise it keeps its value.
- R8: Address 17 reads {3'b000, last five data bits}, with the most recent bit at bit 0.
- R9: `cmd_done` is high for one clock after the first enable edge that follows the last command bit, and this holds even for a count of 0. `dat_done` is high for one clock after the first enable edge that follows the eighth data bit.
- R10: Registers change only on enable edges or on reset. An `arm` received while a capture is in progress is ignored.
- R11: Addresses 18 to 31 read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_en | input | 1 | One-cycle strobe marking each transfer clock |
| rsp_bit | input | 1 | Serial response bit |
| arm | input | 1 | Starts a capture; latches count and flags |
| rsp_bytes | input | 5 | Command response length in bytes |
| spi_mode | input | 1 | Command runs in SPI mode |
| wr_data | input | 1 | Command carries write data |
| host_wr | input | 1 | Host write strobe (clears the addressed register) |
| host_addr | input | 5 | Host register address |
| host_rdata | output | 8 | Addressed register contents |
| cmd_done | output | 1 | Command response captured pulse |
| dat_done | output | 1 | Data response captured pulse |

## Verification
The hardest case to reach is a delayed clear whose second enable edge falls exactly on a shift of the same register. To reach it, the bench writes register 16 while idle and then arms a one-byte command. The clear then lands on the second command bit, and the bench checks that the register keeps only that new bit. The vector walk builds up chain contents over several commands so that older bytes are seen moving down, including a clamped over-long count and a zero count.

// File: rtl/resp_cap_pkg.sv
// Shared types for the response capture block.
package resp_cap_pkg;
    // Capture sequence: command bits, command end edge, data bits, data end edge
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_CEND,
        ST_DAT,
        ST_DEND
    } seq_st_t;
endpackage

// File: rtl/resp_seq.sv
// Capture sequencer. Latches the byte count and flags on arm (idle only),
// counts command shifts, then optionally eight data shifts, and pulses
// done flags on the enable edge after each phase.
// Assumes xfer_en is a single-cycle strobe.
module resp_seq
    import resp_cap_pkg::*;
#(
    parameter int NUM_BYTES = 17,
    parameter int CNT_W     = 5,
    parameter int DAT_BITS  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_en,
    input  logic             arm,
    input  logic [CNT_W-1:0] rsp_bytes,
    input  logic             spi_mode,
    input  logic             wr_data,
    output logic             cmd_shift,
    output logic             dat_shift,
    output logic             cmd_done,
    output logic             dat_done
);
    localparam int BITS_W = $clog2(NUM_BYTES * 8 + 1);
    localparam int DCNT_W = $clog2(DAT_BITS);

    seq_st_t             state_q;
    logic [BITS_W-1:0]   bits_left_q;
    logic [DCNT_W-1:0]   dcnt_q;
    logic                spi_q, wr_q;
    logic [CNT_W-1:0]    eff_bytes;
    logic [BITS_W-1:0]   eff_bits;

    // Clamp the requested byte count to the chain length
    always_comb begin
        eff_bytes = (rsp_bytes > CNT_W'(NUM_BYTES)) ? CNT_W'(NUM_BYTES) : rsp_bytes;
        eff_bits  = BITS_W'(eff_bytes) << 3;
    end

    assign cmd_shift = (state_q == ST_CMD) && xfer_en;
    assign dat_shift = (state_q == ST_DAT) && xfer_en;

    // Phase state, counters and done pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            bits_left_q <= '0;
            dcnt_q      <= '0;
            spi_q       <= 1'b0;
            wr_q        <= 1'b0;
            cmd_done    <= 1'b0;
            dat_done    <= 1'b0;
        end else begin
            cmd_done <= 1'b0;
            dat_done <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (arm) begin
                    spi_q       <= spi_mode;
                    wr_q        <= wr_data;
                    bits_left_q <= eff_bits;
                    state_q     <= (eff_bits == '0) ? ST_CEND : ST_CMD;
                end
                ST_CMD: if (xfer_en) begin
                    bits_left_q <= bits_left_q - 1'b1;
                    if (bits_left_q == BITS_W'(1)) state_q <= ST_CEND;
                end
                ST_CEND: if (xfer_en) begin
                    cmd_done <= 1'b1;
                    dcnt_q   <= '0;
                    state_q  <= (spi_q && wr_q) ? ST_DAT : ST_IDLE;
                end
                ST_DAT: if (xfer_en) begin
                    dcnt_q <= dcnt_q + 1'b1;
                    if (dcnt_q == DCNT_W'(DAT_BITS - 1)) state_q <= ST_DEND;
                end
                ST_DEND: if (xfer_en) begin
                    dat_done <= 1'b1;
                    state_q  <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_DAT_NEEDS_SPI_WR: assert property (@(posedge clk) disable iff (!rst_n)
        dat_shift |-> (spi_q && wr_q)); // R7
    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_done && dat_done)); // R9
    AST_CMD_HAS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CMD) |-> (bits_left_q != '0)); // R3
    AST_DONE_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_done) |-> $past(xfer_en)); // R9
endmodule

// File: rtl/resp_clr_pipe.sv
// Delayed clear pipeline. A host write marks a register; the mark moves one
// stage per enable edge and clears the register on the second edge.
// Assumes write masks are one-hot or zero.
module resp_clr_pipe #(
    parameter int NREG = 18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            xfer_en,
    input  logic [NREG-1:0] wr_mask,
    output logic [NREG-1:0] clr
);
    logic [NREG-1:0] stage_a_q, stage_b_q;

    // Advance pending clears on each transfer edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_a_q <= '0;
            stage_b_q <= '0;
        end else if (xfer_en) begin
            stage_a_q <= wr_mask;
            stage_b_q <= stage_a_q;
        end else begin
            stage_a_q <= stage_a_q | wr_mask;
        end
    end

    assign clr = xfer_en ? stage_b_q : '0;

    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_mask) |=> $countones(stage_a_q) <= 2); // R5
endmodule

// File: rtl/resp_chain.sv
// Storage: seventeen command bytes working as one shift register, entering
// at bit 0 of the top byte, plus a narrow data response register.
// Clear wins over held bits; the incoming bit is still taken.
module resp_chain #(
    parameter int NUM_BYTES = 17,
    parameter int BYTE_W    = 8,
    parameter int DRW       = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             sdi,
    input  logic                             cmd_shift,
    input  logic                             dat_shift,
    input  logic [NUM_BYTES:0]               clr,
    output logic [NUM_BYTES-1:0][BYTE_W-1:0] cmd_q,
    output logic [DRW-1:0]                   dat_q
);
    logic [NUM_BYTES-1:0]             carry_in;
    logic [NUM_BYTES-1:0][BYTE_W-1:0] cmd_nxt;
    logic [DRW-1:0]                   dat_nxt;

    // Serial links: each byte is fed from bit 7 of the byte above
    assign carry_in[NUM_BYTES-1] = sdi;
    for (genvar g = 0; g < NUM_BYTES - 1; g++) begin : g_link
        assign carry_in[g] = cmd_q[g+1][BYTE_W-1];
    end

    // Next-state for every byte and the data register
    always_comb begin
        for (int k = 0; k < NUM_BYTES; k++) begin
            if (cmd_shift)
                cmd_nxt[k] = clr[k] ? {{(BYTE_W-1){1'b0}}, carry_in[k]}
                                    : {cmd_q[k][BYTE_W-2:0], carry_in[k]};
            else if (clr[k])
                cmd_nxt[k] = '0;
            else
                cmd_nxt[k] = cmd_q[k];
        end
        if (dat_shift)
            dat_nxt = clr[NUM_BYTES] ? {{(DRW-1){1'b0}}, sdi} : {dat_q[DRW-2:0], sdi};
        else if (clr[NUM_BYTES])
            dat_nxt = '0;
        else
            dat_nxt = dat_q;
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
            dat_q <= '0;
        end else begin
            cmd_q <= cmd_nxt;
            dat_q <= dat_nxt;
        end
    end

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_chk
        AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            clr[g] |=> (cmd_q[g][BYTE_W-1:1] == '0)); // R6
    end
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_shift && (clr[NUM_BYTES-1:0] == '0)) |=> $stable(cmd_q)); // R10
    AST_DAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dat_shift && !clr[NUM_BYTES]) |=> $stable(dat_q)); // R7
endmodule

// File: rtl/resp_capture.sv
// Top: card response capture. Ties sequencer, clear pipeline and storage
// together and provides the host read mux (0..16 command bytes, 17 data).
module resp_capture #(
    parameter int NUM_BYTES = 17,
    parameter int BYTE_W    = 8,
    parameter int DRW       = 5,
    parameter int CNT_W     = 5,
    parameter int ADDR_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_en,
    input  logic              rsp_bit,
    input  logic              arm,
    input  logic [CNT_W-1:0]  rsp_bytes,
    input  logic              spi_mode,
    input  logic              wr_data,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              cmd_done,
    output logic              dat_done
);
    localparam int NREG = NUM_BYTES + 1;

    logic                             cmd_shift, dat_shift;
    logic [NREG-1:0]                  wr_mask, clr;
    logic [NUM_BYTES-1:0][BYTE_W-1:0] cmd_q;
    logic [DRW-1:0]                   dat_q;

    // Decode host write address into a one-hot clear request
    always_comb begin
        for (int i = 0; i < NREG; i++)
            wr_mask[i] = host_wr && (host_addr == ADDR_W'(i));
    end

    resp_seq #(.NUM_BYTES(NUM_BYTES), .CNT_W(CNT_W), .DAT_BITS(8)) u_seq (
        .clk(clk), .rst_n(rst_n), .xfer_en(xfer_en), .arm(arm),
        .rsp_bytes(rsp_bytes), .spi_mode(spi_mode), .wr_data(wr_data),
        .cmd_shift(cmd_shift), .dat_shift(dat_shift),
        .cmd_done(cmd_done), .dat_done(dat_done)
    );

    resp_clr_pipe #(.NREG(NREG)) u_clr (
        .clk(clk), .rst_n(rst_n), .xfer_en(xfer_en),
        .wr_mask(wr_mask), .clr(clr)
    );

    resp_chain #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W), .DRW(DRW)) u_chain (
        .clk(clk), .rst_n(rst_n), .sdi(rsp_bit),
        .cmd_shift(cmd_shift), .dat_shift(dat_shift), .clr(clr),
        .cmd_q(cmd_q), .dat_q(dat_q)
    );

    // Host read mux; unmapped addresses read zero
    always_comb begin
        host_rdata = '0;
        for (int i = 0; i < NUM_BYTES; i++)
            if (host_addr == ADDR_W'(i)) host_rdata = cmd_q[i];
        if (host_addr == ADDR_W'(NUM_BYTES))
            host_rdata = {{(BYTE_W-DRW){1'b0}}, dat_q};
    end

    AST_DATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == ADDR_W'(NUM_BYTES)) |-> (host_rdata[BYTE_W-1:DRW] == '0)); // R8
    AST_NO_SHIFT_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_shift && dat_shift)); // R7
endmodule

// File: tb/resp_capture_tb.sv
`timescale 1ns/1ps
module resp_capture_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xfer_en = 1'b0, rsp_bit = 1'b0, arm = 1'b0;
    logic [4:0] rsp_bytes = '0;
    logic       spi_mode = 1'b0, wr_data = 1'b0, host_wr = 1'b0;
    logic [4:0] host_addr = '0;
    logic [7:0] host_rdata;
    logic       cmd_done, dat_done;

    int total = 0, bad = 0;
    logic [135:0] m = '0;   // reg a = m[(16-a)*8 +: 8]
    logic [4:0]   d = '0;
    int           clr_addr = -1, clr_cnt = 0;
    logic         saw_cd = 0, saw_dd = 0;
    logic [15:0]  lfsr;

    always #2.5 clk = ~clk;

    resp_capture u_dut (
        .clk(clk), .rst_n(rst_n), .xfer_en(xfer_en), .rsp_bit(rsp_bit),
        .arm(arm), .rsp_bytes(rsp_bytes), .spi_mode(spi_mode),
        .wr_data(wr_data), .host_wr(host_wr), .host_addr(host_addr),
        .host_rdata(host_rdata), .cmd_done(cmd_done), .dat_done(dat_done)
    );

    // {bytes, spi, wr, seed}
    localparam logic [22:0] VEC [6] = '{
        {5'd1,  1'b0, 1'b0, 16'hACE1},
        {5'd5,  1'b1, 1'b1, 16'h1234},
        {5'd17, 1'b1, 1'b0, 16'hBEEF},
        {5'd0,  1'b1, 1'b1, 16'h0F0F},
        {5'd20, 1'b0, 1'b1, 16'h5A5A},
        {5'd3,  1'b1, 1'b1, 16'hC3A5}
    };

    function automatic logic [7:0] exp_reg(input int a);
        if (a < 17) return m[(16-a)*8 +: 8];
        if (a == 17) return {3'b000, d};
        return 8'h00;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        int errs = 0;
        total++;
        for (int a = 0; a < 18; a++) begin
            @(negedge clk); host_addr = 5'(a); #0.5;
            if (host_rdata !== exp_reg(a) && errs == 0) begin
                errs++; bad++;
                $display("FAIL %s: reg%0d actual=%h expected=%h", req, a, host_rdata, exp_reg(a));
            end
        end
    endtask

    function automatic logic next_bit();
        logic b = lfsr[0];
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return b;
    endfunction

    // kind: 0 no shift, 1 command shift, 2 data shift
    task automatic en_bit(input logic b, input int kind);
        @(negedge clk); rsp_bit = b; xfer_en = 1'b1;
        @(negedge clk); xfer_en = 1'b0;
        saw_cd |= cmd_done; saw_dd |= dat_done;
        if (kind == 1) m = {m[134:0], b};
        if (kind == 2) d = {d[3:0], b};
        if (clr_cnt > 0) begin
            clr_cnt--;
            if (clr_cnt == 0) begin
                if (clr_addr < 17)
                    m[(16-clr_addr)*8 +: 8] = (kind == 1) ? {7'b0, m[(16-clr_addr)*8]} : 8'h00;
                else
                    d = (kind == 2) ? {4'b0, d[0]} : 5'h00;
            end
        end
    endtask

    task automatic host_clear(input int a);
        @(negedge clk); host_wr = 1'b1; host_addr = 5'(a);
        @(negedge clk); host_wr = 1'b0;
        if (a < 18) begin clr_addr = a; clr_cnt = 2; end
    endtask

    task automatic do_arm(input logic [4:0] n, input logic s, input logic w);
        @(negedge clk); arm = 1'b1; rsp_bytes = n; spi_mode = s; wr_data = w;
        @(negedge clk); arm = 1'b0;
        saw_cd = 0; saw_dd = 0;
    endtask

    task automatic run_cmd(input logic [4:0] n, input logic s, input logic w, input logic [15:0] seed);
        int nb = (n > 17) ? 17 : int'(n);
        lfsr = seed;
        do_arm(n, s, w);
        for (int i = 0; i < nb * 8; i++) en_bit(next_bit(), 1);
        check("R3 no cmd_done before end edge", {7'b0, saw_cd}, 8'h00);
        en_bit(1'b0, 0);
        check("R9 cmd_done after end edge", {7'b0, saw_cd}, 8'h01);
        if (s && w) begin
            for (int i = 0; i < 8; i++) en_bit(next_bit(), 2);
            check("R7 no dat_done before end edge", {7'b0, saw_dd}, 8'h00);
            en_bit(1'b0, 0);
            check("R9 dat_done after end edge", {7'b0, saw_dd}, 8'h01);
        end else begin
            en_bit(1'b1, 0);
            check("R7 no data capture without spi+wr", {7'b0, saw_dd}, 8'h00);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_all("R1 reset contents");
        check("R1 done flags low", {6'b0, cmd_done, dat_done}, 8'h00);

        // R2 R3 R4 R7 R8 R9: vector walk accumulating chain contents
        foreach (VEC[v]) begin
            run_cmd(VEC[v][22:18], VEC[v][17], VEC[v][16], VEC[v][15:0]);
            check_all("R2 R4 R8 chain contents");
        end

        // R5: delayed clear while idle
        host_clear(5);
        en_bit(1'b1, 0);
        @(negedge clk); host_addr = 5'd5; #0.5;
        check("R5 unchanged after first edge", host_rdata, exp_reg(5));
        en_bit(1'b1, 0);
        @(negedge clk); host_addr = 5'd5; #0.5;
        check("R5 cleared after second edge", host_rdata, 8'h00);

        // R6: clear lands on a shift of the same register
        host_clear(16);
        run_cmd(5'd1, 1'b0, 1'b0, 16'h9D21);
        check_all("R6 clear with shift keeps incoming bit");

        // R11: unmapped reads and writes
        host_clear(20);
        en_bit(1'b0, 0); en_bit(1'b0, 0);
        @(negedge clk); host_addr = 5'd20; #0.5;
        check("R11 unmapped reads zero", host_rdata, 8'h00);
        check_all("R11 unmapped write changes nothing");

        // R10: no change without enable; arm while busy ignored
        do_arm(5'd2, 1'b0, 1'b0);
        repeat (20) @(negedge clk);
        check_all("R10 stable without enable");
        lfsr = 16'h7777;
        for (int i = 0; i < 3; i++) en_bit(next_bit(), 1);
        @(negedge clk); arm = 1'b1; rsp_bytes = 5'd1;
        @(negedge clk); arm = 1'b0;
        for (int i = 0; i < 13; i++) en_bit(next_bit(), 1);
        check("R10 busy arm ignored, no early done", {7'b0, saw_cd}, 8'h00);
        en_bit(1'b0, 0);
        check("R10 done after full original length", {7'b0, saw_cd}, 8'h01);
        check_all("R10 contents after busy arm");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule